// File: doc/BRIEF.md
# Byte-Serial BCH Spare-Area Parity Encoder

This block produces the error-correcting parity that a NAND page carries in its spare area. A stream of message bytes arrives over a valid/ready handshake. Each byte has its two 4-bit halves exchanged and is then folded, most significant bit first, into a 720-bit remainder register. One byte is absorbed per clock.

The code is a binary BCH code built on GF(2^15) with field polynomial x^15 + x + 1, and it corrects 48 bit errors. Its generator polynomial is the product of the minimal polynomials of alpha^1, alpha^3, up to alpha^95, and it is worked out during elaboration. The message is 2080 bytes long, which is 2048 data bytes plus 32 spare bytes.

Once the last message byte is taken, the block drives out the 90-byte remainder, most significant bits first. Each output byte has its halves exchanged again, so the result matches what a controller that swaps nibbles around its BCH engine would store. Identical pages always yield identical parity.

Top module: `bch_page_enc`

## Requirements
- R1: After reset, in_ready is 1 and both par_valid and par_last are 0.
- R2: While parity is being emitted, in_ready is 0. A byte is taken only in a cycle where in_valid and in_ready are both 1.
- R3: par_valid rises in the cycle right after the 2080th message byte is accepted. It then stays high for exactly 90 consecutive cycles.
- R4: par_last is high only together with the 90th parity byte. In the next cycle, par_valid is 0 and in_ready is 1.
- R5: Each message byte enters the code with bits [3:0] and [7:4] exchanged, feeding the swapped bit 7 first. The swapped message bits, first byte first, followed by the parity, form a codeword whose evaluations at alpha^i (odd i from 1 to 95, field polynomial x^15 + x + 1) are all zero.
- R6: Each parity byte is output with its halves exchanged. Once the exchange is undone, the parity bits taken in output order, bit 7 first, are the low-order part of the R5 codeword.
- R7: A page made up only of zero bytes yields 90 zero parity bytes.
- R8: Identical message content yields identical parity, however long the gaps in in_valid are.
- R9: An accepted byte with in_sop at 1 starts a new page. The remainder and the byte count restart from zero before that byte is absorbed, so any bytes accepted earlier have no effect.
- R10: Bytes offered while in_ready is 0, including any with in_sop at 1, are ignored. When a page ends with no start marker, the next page begins from a clean state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A message byte is offered |
| in_ready | output | 1 | The encoder can take a message byte |
| in_sop | input | 1 | The offered byte is the first of a page |
| in_data | input | 8 | Message byte |
| par_valid | output | 1 | par_data holds a parity byte |
| par_data | output | 8 | Parity byte, halves exchanged |
| par_last | output | 1 | The current parity byte is the 90th |

## Verification
The bench checks each new page by evaluating the whole codeword at all 48 odd powers of alpha. A design that forgets one of the two nibble exchanges, reverses the bit order, or uses the wrong taps leaves a nonzero value at some root. A page marker arriving after 37 stray bytes must give the same parity as a clean page; a design that restarts only the count or only the remainder gives different bytes. Junk bytes, some of them flagged as page starts, are held on the input during emission, and the next unmarked page must still match. A design that accepts them or fails to drain the remainder corrupts that page. Gapped input, an all-zero page, and an exact one-cycle latency with a 90-byte window catch off-by-one errors in the counters.

// File: rtl/bch_pkg.sv
package bch_pkg;

    localparam int          GF_M       = 15;
    localparam logic [15:0] FIELD_POLY = 16'h8003;
    localparam int          T_CORR     = 48;
    localparam int          PAR_BITS   = GF_M * T_CORR;
    localparam int          PAR_BYTES  = PAR_BITS / 8;
    localparam int          MSG_BYTES  = 2080;

    // Multiply two elements of GF(2^GF_M).
    function automatic logic [GF_M-1:0] gf_mul(input logic [GF_M-1:0] a,
                                               input logic [GF_M-1:0] b);
        logic [GF_M-1:0] acc;
        logic [GF_M-1:0] sh;
        logic            carry;
        acc = '0;
        sh  = a;
        for (int k = 0; k < GF_M; k++) begin
            if (b[k]) acc = acc ^ sh;
            carry = sh[GF_M-1];
            sh    = {sh[GF_M-2:0], 1'b0};
            if (carry) sh = sh ^ FIELD_POLY[GF_M-1:0];
        end
        return acc;
    endfunction

    // Generator: product of minimal polynomials of alpha^1, alpha^3, ...
    function automatic logic [PAR_BITS:0] gen_poly();
        logic [PAR_BITS+GF_M:0]     g;
        logic [PAR_BITS+GF_M:0]     prod;
        logic [GF_M:0][GF_M-1:0]    coef;
        logic [GF_M-1:0]            root;
        logic [GF_M-1:0]            conj;
        logic                       done;
        g    = '0;
        g[0] = 1'b1;
        root = GF_M'(2);
        for (int i = 1; i < 2 * T_CORR; i += 2) begin
            coef    = '0;
            coef[0] = GF_M'(1);
            conj    = root;
            done    = 1'b0;
            for (int k = 0; k < GF_M; k++) begin
                if (!done) begin
                    for (int j = GF_M; j > 0; j--)
                        coef[j] = coef[j-1] ^ gf_mul(conj, coef[j]);
                    coef[0] = gf_mul(conj, coef[0]);
                    conj    = gf_mul(conj, conj);
                    if (conj == root) done = 1'b1;
                end
            end
            prod = '0;
            for (int j = 0; j <= GF_M; j++)
                if (coef[j][0]) prod = prod ^ (g << j);
            g    = prod;
            root = gf_mul(root, GF_M'(4));
        end
        return g[PAR_BITS:0];
    endfunction

endpackage

// File: rtl/nib_swap.sv
module nib_swap #(
    parameter int LANES = 1
) (
    input  logic [8*LANES-1:0] din,
    output logic [8*LANES-1:0] dout
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[8*g +: 8] = {din[8*g +: 4], din[8*g+4 +: 4]};
    end
endmodule

// File: rtl/par_lfsr_step.sv
module par_lfsr_step #(
    parameter int               WIDTH = 720,
    parameter logic [WIDTH-1:0] TAPS  = '0
) (
    input  logic [WIDTH-1:0] rem_in,
    input  logic [7:0]       byte_in,
    output logic [WIDTH-1:0] rem_out
);
    // Eight bit-serial division steps, unrolled; message bit 7 first.
    always_comb begin
        logic [WIDTH-1:0] r;
        logic             fb;
        r = rem_in;
        for (int b = 7; b >= 0; b--) begin
            fb = byte_in[b] ^ r[WIDTH-1];
            r  = {r[WIDTH-2:0], 1'b0} ^ (fb ? TAPS : '0);
        end
        rem_out = r;
    end
endmodule

// File: rtl/bch_page_enc.sv
module bch_page_enc #(
    parameter int MSG_LEN = bch_pkg::MSG_BYTES
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic       in_sop,
    input  logic [7:0] in_data,
    output logic       par_valid,
    output logic [7:0] par_data,
    output logic       par_last
);
    import bch_pkg::*;

    localparam logic [PAR_BITS:0]   GEN_POLY = gen_poly();
    localparam logic [PAR_BITS-1:0] TAPS     = GEN_POLY[PAR_BITS-1:0];
    localparam int CNT_W  = $clog2(MSG_LEN + 1);
    localparam int EMIT_W = $clog2(PAR_BYTES);

    typedef enum logic {ST_ABSORB = 1'b0, ST_EMIT = 1'b1} mode_t;

    typedef struct packed {
        mode_t               mode;
        logic [CNT_W-1:0]    cnt;
        logic [EMIT_W-1:0]   emit_idx;
        logic [PAR_BITS-1:0] rem;
    } enc_state_t;

    enc_state_t st_d, st_q;

    logic                accept;
    logic [PAR_BITS-1:0] base_rem;
    logic [CNT_W-1:0]    base_cnt;
    logic [7:0]          msg_sw;
    logic [PAR_BITS-1:0] step_rem;
    logic [7:0]          par_raw;

    nib_swap #(.LANES(1)) u_in_swap (.din(in_data), .dout(msg_sw));

    par_lfsr_step #(.WIDTH(PAR_BITS), .TAPS(TAPS)) u_step (
        .rem_in (base_rem),
        .byte_in(msg_sw),
        .rem_out(step_rem)
    );

    assign par_raw = st_q.rem[PAR_BITS-1 -: 8];
    nib_swap #(.LANES(1)) u_out_swap (.din(par_raw), .dout(par_data));

    assign in_ready  = (st_q.mode == ST_ABSORB);
    assign par_valid = (st_q.mode == ST_EMIT);
    assign par_last  = par_valid && (st_q.emit_idx == EMIT_W'(PAR_BYTES - 1));
    assign accept    = in_valid && in_ready;

    always_comb begin
        base_rem = in_sop ? '0 : st_q.rem;
        base_cnt = in_sop ? '0 : st_q.cnt;
        st_d     = st_q;
        if (st_q.mode == ST_ABSORB) begin
            if (accept) begin
                st_d.rem = step_rem;
                if (base_cnt == CNT_W'(MSG_LEN - 1)) begin
                    st_d.cnt      = '0;
                    st_d.mode     = ST_EMIT;
                    st_d.emit_idx = '0;
                end else begin
                    st_d.cnt = base_cnt + CNT_W'(1);
                end
            end
        end else begin
            st_d.rem = {st_q.rem[PAR_BITS-9:0], 8'h00};
            if (st_q.emit_idx == EMIT_W'(PAR_BYTES - 1)) begin
                st_d.mode     = ST_ABSORB;
                st_d.emit_idx = '0;
            end else begin
                st_d.emit_idx = st_q.emit_idx + EMIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: ST_ABSORB, cnt: '0, emit_idx: '0, rem: '0};
        else        st_q <= st_d;
    end

    // Input is closed during emission.
    assert_no_accept_in_emit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        par_valid |-> !in_ready);

    // Emission window is unbroken until its last byte.
    assert_emit_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
        par_valid && !par_last |=> par_valid);

    // Emission opens only right after an accepted byte.
    assert_emit_follows_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(par_valid) |-> $past(in_valid && in_ready));

    assert_last_in_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        par_last |-> par_valid);

    assert_last_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        par_last |=> (!par_valid && in_ready));

endmodule

// File: tb/tb_bch_page_enc.sv
module tb_bch_page_enc;

    localparam int NMSG = 2080;
    localparam int NPAR = 90;
    localparam int NROOT = 48;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_sop = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, par_valid, par_last;
    logic [7:0] par_data;

    bch_page_enc dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sop(in_sop), .in_data(in_data), .par_valid(par_valid),
        .par_data(par_data), .par_last(par_last)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_acc_cyc = 0;
    int first_par_cyc = 0;
    int cap_idx = 0;
    int pages_done = 0;
    string exp_tag = "R7";

    logic [7:0] msg     [NMSG];
    logic [7:0] cap     [NPAR];
    logic [7:0] ref_par [NPAR];
    logic [7:0] exp_q   [$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && par_valid) begin
            logic [7:0] e;
            if (cap_idx == 0) begin
                first_par_cyc = cyc;
                check(first_par_cyc - last_acc_cyc == 1, "R3", "parity start latency",
                      first_par_cyc - last_acc_cyc, 1);
            end
            check(in_ready == 1'b0, "R2", "in_ready during emission", in_ready, 0);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(par_data == e, exp_tag, "parity byte", par_data, e);
            end
            if (cap_idx < NPAR) cap[cap_idx] = par_data;
            cap_idx++;
            if (par_last) begin
                check(cap_idx == NPAR, "R4", "parity bytes before last", cap_idx, NPAR);
                pages_done++;
                cap_idx = 0;
            end
        end
    end

    function automatic logic [14:0] tb_gmul(input logic [14:0] a, input logic [14:0] b);
        logic [15:0] p;
        p = '0;
        for (int k = 14; k >= 0; k--) begin
            p = p << 1;
            if (p[15]) p = p ^ 16'h8003;
            if (b[k]) p = p ^ {1'b0, a};
        end
        return p[14:0];
    endfunction

    task automatic syn_check(input string what);
        logic [14:0] ai, s;
        logic [7:0]  sw;
        int bad = 0;
        ai = 15'd2;
        for (int r = 0; r < NROOT; r++) begin
            s = '0;
            for (int k = 0; k < NMSG; k++) begin
                sw = {msg[k][3:0], msg[k][7:4]};
                for (int b = 7; b >= 0; b--) s = tb_gmul(s, ai) ^ {14'd0, sw[b]};
            end
            for (int k = 0; k < NPAR; k++) begin
                sw = {cap[k][3:0], cap[k][7:4]};
                for (int b = 7; b >= 0; b--) s = tb_gmul(s, ai) ^ {14'd0, sw[b]};
            end
            if (s != 0) bad++;
            ai = tb_gmul(ai, 15'd4);
        end
        check(bad == 0, "R5 R6", what, bad, 0);
    endtask

    task automatic send_byte(input logic [7:0] d, input bit sop, input int gap);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_sop   = sop;
        while (!in_ready) @(negedge clk);
        last_acc_cyc = cyc;
    endtask

    task automatic send_page(input bit gaps, input bit sop_first, input bit junk);
        int tgt;
        tgt = pages_done + 1;
        for (int i = 0; i < NMSG; i++)
            send_byte(msg[i], sop_first && (i == 0),
                      (gaps && ($urandom % 3 == 0)) ? int'($urandom % 3) : 0);
        if (junk) begin
            forever begin
                @(negedge clk);
                if (in_ready) break;
                in_valid = 1'b1;
                in_sop   = 1'b1;
                in_data  = 8'($urandom);
            end
            in_valid = 1'b0;
            in_sop   = 1'b0;
        end else begin
            @(negedge clk);
            in_valid = 1'b0;
            in_sop   = 1'b0;
        end
        while (pages_done < tgt) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        check(par_valid == 1'b0, "R1", "par_valid after reset", par_valid, 0);
        check(par_last == 1'b0, "R1", "par_last after reset", par_last, 0);

        // R7: zero page gives zero parity
        for (int i = 0; i < NMSG; i++) msg[i] = 8'h00;
        exp_tag = "R7";
        for (int i = 0; i < NPAR; i++) exp_q.push_back(8'h00);
        send_page(1'b0, 1'b1, 1'b0);
        check(exp_q.size() == 0, "R7", "expected bytes left", exp_q.size(), 0);

        // R5 R6: random page, verified by roots of the code
        for (int i = 0; i < NMSG; i++) msg[i] = 8'($urandom);
        send_page(1'b0, 1'b1, 1'b0);
        syn_check("random page syndromes");
        for (int i = 0; i < NPAR; i++) ref_par[i] = cap[i];

        // R8: same page with input gaps, junk offered during emission
        exp_tag = "R8";
        for (int i = 0; i < NPAR; i++) exp_q.push_back(ref_par[i]);
        send_page(1'b1, 1'b1, 1'b1);

        // R10: unmarked page after junk during emission
        exp_tag = "R10";
        for (int i = 0; i < NPAR; i++) exp_q.push_back(ref_par[i]);
        send_page(1'b0, 1'b0, 1'b0);

        // R9: stray bytes then a marked page
        for (int i = 0; i < 37; i++) send_byte(8'($urandom), 1'b0, 0);
        exp_tag = "R9";
        for (int i = 0; i < NPAR; i++) exp_q.push_back(ref_par[i]);
        send_page(1'b0, 1'b1, 1'b0);

        // R5 R6: single set bit in first byte
        for (int i = 0; i < NMSG; i++) msg[i] = 8'h00;
        msg[0] = 8'h01;
        send_page(1'b0, 1'b1, 1'b0);
        syn_check("single bit page syndromes");

        // R5 R6: patterned page
        for (int i = 0; i < NMSG; i++) msg[i] = 8'(i * 37 + 5);
        send_page(1'b1, 1'b1, 1'b0);
        syn_check("patterned page syndromes");

        check(exp_q.size() == 0, "R8", "scoreboard drained", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule